// File: doc/BRIEF.md
# Memory Security Attribution Checker

This block gives every bus access and every instruction fetch address a security class: secure, non-secure, or non-secure-callable. Two sources set the class. The first is a small table of programmable address windows. The second is a fixed map built into the block, which assigns a class to each sixteenth of the address space. When the table is on, the more secure of the two answers is used.

Each access carries the security state of its requester. The block checks that state against the class of the target address. A non-secure requester may touch only non-secure memory. It may enter secure code only by branching onto a gateway entry that lies inside a callable window. A violation produces a one-cycle fault pulse with a 2-bit cause. In the full build the pulse appears on a dedicated security-fault line. In the reduced build it appears on a generic hard-fault line.

A separate query port returns the class of any address. A secure issuer also learns which programmable window matched and whether that window is callable.

Top module: `sec_attr_checker`

## Requirements
- R1: An access whose requester is secure (`acc_ns`=0) never raises a fault, whatever the class of its address.
- R2: A non-secure data access (`acc_branch`=0) to an address of class secure or non-secure-callable pulses a fault with cause 1. A non-secure data access to a non-secure address does not fault.
- R3: A non-secure branch (`acc_branch`=1) follows these rules:
  - To a secure address, it faults with cause 2.
  - To a callable address without `acc_gateway`, it faults with cause 3.
  - To a callable address with `acc_gateway`, it does not fault.
  - To a non-secure address, it does not fault.
- R4: While the table is disabled, the class of an address is the fixed-map class.
  - The fixed map is indexed by address bits [31:28].
  - If the bit for that index is set in `FIXED_NSC_MASK`, the class is callable.
  - Otherwise, if the bit is set in `FIXED_NS_MASK`, the class is non-secure.
  - Otherwise, the class is secure.
  - Class codes on `qry_attr` are 0 = non-secure, 1 = callable, 2 = secure.
- R5: While the table is enabled, the table class is found as follows:
  - An address inside an enabled window takes that window's class: callable if its callable flag is set, otherwise non-secure.
  - An address outside every enabled window is secure.
  - The final class is the more secure of the table class and the fixed-map class.
- R6: A window covers every address whose bits [31:5] lie between its base and its limit, both ends included. Address bits [4:0] take no part in the comparison, so the whole 32-byte block at the limit is covered.
- R7: A query returns its result one cycle after `qry_valid`, with `qry_done` high for that cycle.
  - For a secure issuer, `qry_hit` tells whether an enabled window matched while the table is on. `qry_idx` then gives the lowest matching window index, and `qry_nsc` gives that window's callable flag.
  - For a non-secure issuer, `qry_hit`, `qry_idx` and `qry_nsc` are 0.
- R8: With `FULL_CFG`=1, violations appear on `fault_sec` and `fault_hard` stays 0. With `FULL_CFG`=0, violations appear on `fault_hard` and `fault_sec` stays 0.
- R9: A fault is a pulse lasting exactly one cycle. It appears in the cycle after the violating `acc_valid` cycle, together with its cause. A cycle with no violating access gives no fault and a cause of 0.
- R10: A write with `cfg_we`=1 updates the configuration selected by `cfg_kind`; the write is visible from the next cycle.
  - `cfg_kind`=0 sets the base of window `cfg_idx` from `cfg_wdata[31:5]`.
  - `cfg_kind`=1 sets the limit of window `cfg_idx` from `cfg_wdata[31:5]`, its enable from bit 0 and its callable flag from bit 1.
  - `cfg_kind`=2 sets the table enable from bit 0.
- R11: After reset the table is disabled, all windows are disabled, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 base, 1 limit/flags, 2 table control |
| cfg_idx | input | IDX_W | Window index for the write |
| cfg_wdata | input | ADDR_W | Write data |
| acc_valid | input | 1 | Access request valid |
| acc_addr | input | ADDR_W | Access address |
| acc_ns | input | 1 | Requester is non-secure |
| acc_branch | input | 1 | Access is a branch or fetch target |
| acc_gateway | input | 1 | Target word is a gateway entry |
| fault_sec | output | 1 | Security fault pulse (full build) |
| fault_hard | output | 1 | Hard fault pulse (reduced build) |
| fault_cause | output | 2 | 0 none, 1 data, 2 branch, 3 missing gateway |
| qry_valid | input | 1 | Query request valid |
| qry_addr | input | ADDR_W | Query address |
| qry_ns | input | 1 | Query issuer is non-secure |
| qry_done | output | 1 | Query result valid |
| qry_attr | output | 2 | Class of the queried address |
| qry_hit | output | 1 | A window matched (secure issuer only) |
| qry_idx | output | IDX_W | Matching window index (secure issuer only) |
| qry_nsc | output | 1 | Callable flag of the matched window (secure issuer only) |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- A configuration write takes effect at the edge that samples it.
- A fault pulse and its cause are registered at the edge that samples `acc_valid`.
- Query results are registered at the edge that samples `qry_valid`.

The bench drives each stimulus on a falling edge and holds it for one cycle. It reads the outputs on the following falling edge, which is exactly one rising edge later. It checks the fault lines again one cycle after that, to confirm the pulse has ended. A full-build and a reduced-build instance share the same inputs, so both fault routes are compared on the same cycle.

// File: rtl/sac_pkg.sv
package sac_pkg;

    typedef enum logic [1:0] {
        ATTR_NS  = 2'd0,
        ATTR_NSC = 2'd1,
        ATTR_S   = 2'd2
    } attr_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_DATA    = 2'd1,
        CAUSE_BRANCH  = 2'd2,
        CAUSE_GATEWAY = 2'd3
    } cause_e;

    localparam logic [1:0] KIND_BASE  = 2'd0;
    localparam logic [1:0] KIND_LIMIT = 2'd1;
    localparam logic [1:0] KIND_CTRL  = 2'd2;

    localparam int GRAN_BITS = 5;

    function automatic attr_e attr_max(attr_e a, attr_e b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sac_region_file.sv
module sac_region_file #(
    parameter int ADDR_W      = 32,
    parameter int NUM_REGIONS = 4,
    parameter int IDX_W       = 2,
    parameter int BLK_W       = ADDR_W - sac_pkg::GRAN_BITS
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [1:0]                        cfg_kind,
    input  logic [IDX_W-1:0]                  cfg_idx,
    input  logic [ADDR_W-1:0]                 cfg_wdata,
    output logic                              table_en,
    output logic [NUM_REGIONS-1:0][BLK_W-1:0] reg_base,
    output logic [NUM_REGIONS-1:0][BLK_W-1:0] reg_limit,
    output logic [NUM_REGIONS-1:0]            reg_en,
    output logic [NUM_REGIONS-1:0]            reg_nsc
);
    import sac_pkg::*;

    typedef struct packed {
        logic                              tbl_en;
        logic [NUM_REGIONS-1:0][BLK_W-1:0] base;
        logic [NUM_REGIONS-1:0][BLK_W-1:0] limit;
        logic [NUM_REGIONS-1:0]            en;
        logic [NUM_REGIONS-1:0]            nsc;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^cfg_wdata[GRAN_BITS-1:2];

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (cfg_kind == KIND_CTRL) begin
                st_d.tbl_en = cfg_wdata[0];
            end
            for (int i = 0; i < NUM_REGIONS; i++) begin
                if (cfg_idx == i[IDX_W-1:0]) begin
                    if (cfg_kind == KIND_BASE) begin
                        st_d.base[i] = cfg_wdata[ADDR_W-1:GRAN_BITS];
                    end
                    if (cfg_kind == KIND_LIMIT) begin
                        st_d.limit[i] = cfg_wdata[ADDR_W-1:GRAN_BITS];
                        st_d.en[i]    = cfg_wdata[0];
                        st_d.nsc[i]   = cfg_wdata[1];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign table_en  = st_q.tbl_en;
    assign reg_base  = st_q.base;
    assign reg_limit = st_q.limit;
    assign reg_en    = st_q.en;
    assign reg_nsc   = st_q.nsc;

endmodule

// File: rtl/sac_attr_lookup.sv
module sac_attr_lookup #(
    parameter int               ADDR_W         = 32,
    parameter int               NUM_REGIONS    = 4,
    parameter int               IDX_W          = 2,
    parameter logic [15:0]      FIXED_NS_MASK  = 16'h00F0,
    parameter logic [15:0]      FIXED_NSC_MASK = 16'h0002,
    parameter int               BLK_W          = ADDR_W - sac_pkg::GRAN_BITS
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              table_en,
    input  logic [NUM_REGIONS-1:0][BLK_W-1:0] reg_base,
    input  logic [NUM_REGIONS-1:0][BLK_W-1:0] reg_limit,
    input  logic [NUM_REGIONS-1:0]            reg_en,
    input  logic [NUM_REGIONS-1:0]            reg_nsc,
    output sac_pkg::attr_e                    attr,
    output logic                              hit,
    output logic [IDX_W-1:0]                  idx,
    output logic                              hit_nsc
);
    import sac_pkg::*;

    localparam int SLICE_LSB = ADDR_W - 4;

    logic [BLK_W-1:0] blk;
    logic [3:0]       slice;
    logic [NUM_REGIONS-1:0] match;
    attr_e            fixed_attr;
    attr_e            tbl_attr;
    logic             any_hit;
    logic [IDX_W-1:0] hit_idx;
    logic             sel_nsc;
    logic             unused_low_bits;

    assign blk             = addr[ADDR_W-1:GRAN_BITS];
    assign slice           = addr[ADDR_W-1:SLICE_LSB];
    assign unused_low_bits = ^addr[GRAN_BITS-1:0];

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        assign match[g] = reg_en[g] && (blk >= reg_base[g]) && (blk <= reg_limit[g]);
    end

    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        sel_nsc = 1'b0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (match[i]) begin
                any_hit = 1'b1;
                hit_idx = i[IDX_W-1:0];
                sel_nsc = reg_nsc[i];
            end
        end
    end

    always_comb begin
        if (FIXED_NSC_MASK[slice]) begin
            fixed_attr = ATTR_NSC;
        end else if (FIXED_NS_MASK[slice]) begin
            fixed_attr = ATTR_NS;
        end else begin
            fixed_attr = ATTR_S;
        end
    end

    always_comb begin
        if (!any_hit) begin
            tbl_attr = ATTR_S;
        end else if (sel_nsc) begin
            tbl_attr = ATTR_NSC;
        end else begin
            tbl_attr = ATTR_NS;
        end
    end

    assign attr    = table_en ? attr_max(tbl_attr, fixed_attr) : fixed_attr;
    assign hit     = table_en && any_hit;
    assign idx     = table_en ? hit_idx : '0;
    assign hit_nsc = table_en && any_hit && sel_nsc;

endmodule

// File: rtl/sac_fault_eval.sv
module sac_fault_eval (
    input  logic             valid,
    input  logic             req_ns,
    input  logic             branch,
    input  logic             gateway,
    input  sac_pkg::attr_e   attr,
    output sac_pkg::cause_e  cause
);
    import sac_pkg::*;

    always_comb begin
        cause = CAUSE_NONE;
        if (valid && req_ns) begin
            if (branch) begin
                if (attr == ATTR_S) begin
                    cause = CAUSE_BRANCH;
                end else if (attr == ATTR_NSC && !gateway) begin
                    cause = CAUSE_GATEWAY;
                end
            end else if (attr != ATTR_NS) begin
                cause = CAUSE_DATA;
            end
        end
    end

endmodule

// File: rtl/sec_attr_checker.sv
module sec_attr_checker #(
    parameter int          ADDR_W         = 32,
    parameter int          NUM_REGIONS    = 4,
    parameter bit          FULL_CFG       = 1'b1,
    parameter logic [15:0] FIXED_NS_MASK  = 16'h00F0,
    parameter logic [15:0] FIXED_NSC_MASK = 16'h0002,
    parameter int          IDX_W          = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_ns,
    input  logic              acc_branch,
    input  logic              acc_gateway,
    output logic              fault_sec,
    output logic              fault_hard,
    output logic [1:0]        fault_cause,
    input  logic              qry_valid,
    input  logic [ADDR_W-1:0] qry_addr,
    input  logic              qry_ns,
    output logic              qry_done,
    output logic [1:0]        qry_attr,
    output logic              qry_hit,
    output logic [IDX_W-1:0]  qry_idx,
    output logic              qry_nsc
);
    import sac_pkg::*;

    localparam int BLK_W = ADDR_W - GRAN_BITS;

    logic                              table_en;
    logic [NUM_REGIONS-1:0][BLK_W-1:0] reg_base;
    logic [NUM_REGIONS-1:0][BLK_W-1:0] reg_limit;
    logic [NUM_REGIONS-1:0]            reg_en;
    logic [NUM_REGIONS-1:0]            reg_nsc;

    attr_e            acc_attr;
    logic             acc_hit_unused;
    logic [IDX_W-1:0] acc_idx_unused;
    logic             acc_nsc_unused;
    cause_e           acc_cause;

    attr_e            q_attr;
    logic             q_hit;
    logic [IDX_W-1:0] q_idx;
    logic             q_nsc;

    logic unused_acc_side;
    assign unused_acc_side = acc_hit_unused ^ (^acc_idx_unused) ^ acc_nsc_unused;

    sac_region_file #(
        .ADDR_W      (ADDR_W),
        .NUM_REGIONS (NUM_REGIONS),
        .IDX_W       (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .table_en  (table_en),
        .reg_base  (reg_base),
        .reg_limit (reg_limit),
        .reg_en    (reg_en),
        .reg_nsc   (reg_nsc)
    );

    sac_attr_lookup #(
        .ADDR_W         (ADDR_W),
        .NUM_REGIONS    (NUM_REGIONS),
        .IDX_W          (IDX_W),
        .FIXED_NS_MASK  (FIXED_NS_MASK),
        .FIXED_NSC_MASK (FIXED_NSC_MASK)
    ) u_acc_lookup (
        .addr      (acc_addr),
        .table_en  (table_en),
        .reg_base  (reg_base),
        .reg_limit (reg_limit),
        .reg_en    (reg_en),
        .reg_nsc   (reg_nsc),
        .attr      (acc_attr),
        .hit       (acc_hit_unused),
        .idx       (acc_idx_unused),
        .hit_nsc   (acc_nsc_unused)
    );

    sac_attr_lookup #(
        .ADDR_W         (ADDR_W),
        .NUM_REGIONS    (NUM_REGIONS),
        .IDX_W          (IDX_W),
        .FIXED_NS_MASK  (FIXED_NS_MASK),
        .FIXED_NSC_MASK (FIXED_NSC_MASK)
    ) u_qry_lookup (
        .addr      (qry_addr),
        .table_en  (table_en),
        .reg_base  (reg_base),
        .reg_limit (reg_limit),
        .reg_en    (reg_en),
        .reg_nsc   (reg_nsc),
        .attr      (q_attr),
        .hit       (q_hit),
        .idx       (q_idx),
        .hit_nsc   (q_nsc)
    );

    sac_fault_eval u_eval (
        .valid   (acc_valid),
        .req_ns  (acc_ns),
        .branch  (acc_branch),
        .gateway (acc_gateway),
        .attr    (acc_attr),
        .cause   (acc_cause)
    );

    typedef struct packed {
        logic             f_sec;
        logic             f_hard;
        logic [1:0]       cause;
        logic             q_done;
        logic [1:0]       q_attr;
        logic             q_hit;
        logic [IDX_W-1:0] q_idx;
        logic             q_nsc;
    } out_state_t;

    out_state_t o_d, o_q;

    always_comb begin
        o_d        = o_q;
        o_d.cause  = acc_cause;
        o_d.f_sec  = 1'b0;
        o_d.f_hard = 1'b0;
        if (acc_cause != CAUSE_NONE) begin
            if (FULL_CFG) begin
                o_d.f_sec = 1'b1;
            end else begin
                o_d.f_hard = 1'b1;
            end
        end
        o_d.q_done = qry_valid;
        if (qry_valid) begin
            o_d.q_attr = q_attr;
            if (qry_ns) begin
                o_d.q_hit = 1'b0;
                o_d.q_idx = '0;
                o_d.q_nsc = 1'b0;
            end else begin
                o_d.q_hit = q_hit;
                o_d.q_idx = q_idx;
                o_d.q_nsc = q_nsc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign fault_sec   = o_q.f_sec;
    assign fault_hard  = o_q.f_hard;
    assign fault_cause = o_q.cause;
    assign qry_done    = o_q.q_done;
    assign qry_attr    = o_q.q_attr;
    assign qry_hit     = o_q.q_hit;
    assign qry_idx     = o_q.q_idx;
    assign qry_nsc     = o_q.q_nsc;

endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
    parameter int IDX_W    = 2,
    parameter bit FULL_CFG = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             acc_ns,
    input logic             fault_sec,
    input logic             fault_hard,
    input logic [1:0]       fault_cause,
    input logic             qry_valid,
    input logic             qry_ns,
    input logic             qry_done,
    input logic             qry_hit,
    input logic [IDX_W-1:0] qry_idx
);

    p_secure_no_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ns) |=> (!fault_sec && !fault_hard));

    p_fault_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_sec || fault_hard) |-> (fault_cause != 2'd0));

    p_no_req_no_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!fault_sec && !fault_hard && fault_cause == 2'd0));

    p_one_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_sec, fault_hard}));

    p_route_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_sec || fault_hard) |-> (fault_sec == FULL_CFG));

    p_ns_query_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_valid && qry_ns) |=> (qry_done && !qry_hit && qry_idx == '0));

    p_query_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid |=> qry_done);

endmodule

bind sec_attr_checker sac_checker #(
    .IDX_W    (IDX_W),
    .FULL_CFG (FULL_CFG)
) u_sac_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_ns      (acc_ns),
    .fault_sec   (fault_sec),
    .fault_hard  (fault_hard),
    .fault_cause (fault_cause),
    .qry_valid   (qry_valid),
    .qry_ns      (qry_ns),
    .qry_done    (qry_done),
    .qry_hit     (qry_hit),
    .qry_idx     (qry_idx)
);

// File: tb/sec_attr_checker_test.sv
module sec_attr_checker_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int IW         = 2;

    localparam logic [1:0] A_NS = 2'd0, A_NSC = 2'd1, A_S = 2'd2;
    localparam logic [1:0] C_NONE = 2'd0, C_DATA = 2'd1, C_BR = 2'd2, C_GW = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_kind = '0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_ns = 1'b0;
    logic          acc_branch = 1'b0;
    logic          acc_gateway = 1'b0;
    logic          qry_valid = 1'b0;
    logic [AW-1:0] qry_addr = '0;
    logic          qry_ns = 1'b0;

    logic          f_sec, f_hard, l_sec, l_hard;
    logic [1:0]    f_cause, l_cause;
    logic          q_done, q_hit, q_nsc;
    logic [1:0]    q_attr;
    logic [IW-1:0] q_idx;
    logic          lq_done, lq_hit, lq_nsc;
    logic [1:0]    lq_attr;
    logic [IW-1:0] lq_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_attr_checker #(.FULL_CFG(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_ns(acc_ns), .acc_branch(acc_branch),
        .acc_gateway(acc_gateway), .fault_sec(f_sec), .fault_hard(f_hard),
        .fault_cause(f_cause), .qry_valid(qry_valid), .qry_addr(qry_addr),
        .qry_ns(qry_ns), .qry_done(q_done), .qry_attr(q_attr), .qry_hit(q_hit),
        .qry_idx(q_idx), .qry_nsc(q_nsc)
    );

    sec_attr_checker #(.FULL_CFG(1'b0)) uut_lite (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_ns(acc_ns), .acc_branch(acc_branch),
        .acc_gateway(acc_gateway), .fault_sec(l_sec), .fault_hard(l_hard),
        .fault_cause(l_cause), .qry_valid(qry_valid), .qry_addr(qry_addr),
        .qry_ns(qry_ns), .qry_done(lq_done), .qry_attr(lq_attr), .qry_hit(lq_hit),
        .qry_idx(lq_idx), .qry_nsc(lq_nsc)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] kind, input int idx, input logic [AW-1:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_kind  = kind;
        cfg_idx   = idx[IW-1:0];
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // One access; fault expected one edge later, then gone the next cycle.
    task automatic access(input string tag, input logic [AW-1:0] a, input logic ns,
                          input logic br, input logic gw, input logic [1:0] exp_cause);
        @(negedge clk);
        acc_valid   = 1'b1;
        acc_addr    = a;
        acc_ns      = ns;
        acc_branch  = br;
        acc_gateway = gw;
        @(negedge clk);
        acc_valid   = 1'b0;
        check({tag, " cause"}, {30'd0, f_cause}, {30'd0, exp_cause});
        check({tag, " fault_sec R8"}, {31'd0, f_sec}, {31'd0, exp_cause != C_NONE});
        check({tag, " fault_hard R8"}, {31'd0, f_hard}, 32'd0);
        check({tag, " lite hard R8"}, {31'd0, l_hard}, {31'd0, exp_cause != C_NONE});
        check({tag, " lite sec R8"}, {31'd0, l_sec}, 32'd0);
        @(negedge clk);
        check({tag, " pulse end R9"}, {30'd0, f_sec, l_hard}, 32'd0);
    endtask

    task automatic query(input string tag, input logic [AW-1:0] a, input logic ns,
                         input logic [1:0] exp_attr, input logic exp_hit,
                         input int exp_idx, input logic exp_nsc);
        @(negedge clk);
        qry_valid = 1'b1;
        qry_addr  = a;
        qry_ns    = ns;
        @(negedge clk);
        qry_valid = 1'b0;
        check({tag, " done R7"}, {31'd0, q_done}, 32'd1);
        check({tag, " attr"}, {30'd0, q_attr}, {30'd0, exp_attr});
        check({tag, " hit R7"}, {31'd0, q_hit}, {31'd0, exp_hit});
        check({tag, " idx R7"}, {30'd0, q_idx}, exp_idx);
        check({tag, " nsc R7"}, {31'd0, q_nsc}, {31'd0, exp_nsc});
    endtask

    task automatic t_reset;
        check("R11 fault_sec after reset", {31'd0, f_sec}, 32'd0);
        check("R11 fault_hard after reset", {31'd0, l_hard}, 32'd0);
        check("R11 cause after reset", {30'd0, f_cause}, 32'd0);
        check("R11 qry_done after reset", {31'd0, q_done}, 32'd0);
        check("R11 qry_attr after reset", {30'd0, q_attr}, 32'd0);
        // table disabled and no windows: 0x4 slice stays NS per fixed map
        query("R11 table off", 32'h4000_0000, 1'b0, A_NS, 1'b0, 0, 1'b0);
    endtask

    task automatic t_fixed_map;
        query("R4 fixed secure", 32'h0000_1000, 1'b0, A_S, 1'b0, 0, 1'b0);
        query("R4 fixed callable", 32'h1000_0040, 1'b0, A_NSC, 1'b0, 0, 1'b0);
        query("R4 fixed nonsecure", 32'h7FFF_FFFF, 1'b1, A_NS, 1'b0, 0, 1'b0);
        query("R4 fixed above NS", 32'h8000_0000, 1'b0, A_S, 1'b0, 0, 1'b0);
    endtask

    task automatic t_faults_table_off;
        access("R2 ns data to S", 32'h0000_1000, 1'b1, 1'b0, 1'b0, C_DATA);
        access("R2 ns data to NSC", 32'h1000_0000, 1'b1, 1'b0, 1'b0, C_DATA);
        access("R2 ns data to NS", 32'h5000_0000, 1'b1, 1'b0, 1'b0, C_NONE);
        access("R1 secure data to S", 32'h0000_1000, 1'b0, 1'b0, 1'b0, C_NONE);
        access("R3 ns branch to fixed NSC gw", 32'h1000_0020, 1'b1, 1'b1, 1'b1, C_NONE);
        access("R3 ns branch to fixed NSC no gw", 32'h1000_0020, 1'b1, 1'b1, 1'b0, C_GW);
    endtask

    task automatic t_program;
        cfg_write(2'd0, 0, 32'h4000_0000);
        cfg_write(2'd1, 0, 32'h4000_0FE0 | 32'h1);        // NS, enabled
        cfg_write(2'd0, 1, 32'h4000_1000);
        cfg_write(2'd1, 1, 32'h4000_10E0 | 32'h3);        // NSC, enabled
        cfg_write(2'd0, 2, 32'h2000_0000);
        cfg_write(2'd1, 2, 32'h2000_00E0 | 32'h1);        // NS over fixed S
        // R10: windows configured but table still off, fixed map applies
        query("R10 table off after cfg", 32'h4000_2000, 1'b0, A_NS, 1'b0, 0, 1'b0);
        cfg_write(2'd2, 0, 32'h1);
        query("R10 R5 outside windows", 32'h4000_2000, 1'b0, A_S, 1'b0, 0, 1'b0);
    endtask

    task automatic t_table_on;
        query("R6 last byte of limit blk", 32'h4000_0FFF, 1'b0, A_NS, 1'b1, 0, 1'b0);
        query("R6 first byte of base", 32'h4000_0000, 1'b0, A_NS, 1'b1, 0, 1'b0);
        query("R6 just below base", 32'h3FFF_FFE0, 1'b0, A_S, 1'b0, 0, 1'b0);
        query("R5 callable window", 32'h4000_1004, 1'b0, A_NSC, 1'b1, 1, 1'b1);
        query("R7 ns issuer hides window", 32'h4000_1004, 1'b1, A_NSC, 1'b0, 0, 1'b0);
        query("R5 more secure wins", 32'h2000_0010, 1'b0, A_S, 1'b1, 2, 1'b0);
        access("R3 gateway into window", 32'h4000_1004, 1'b1, 1'b1, 1'b1, C_NONE);
        access("R3 missing gateway", 32'h4000_1004, 1'b1, 1'b1, 1'b0, C_GW);
        access("R3 branch into secure", 32'h4000_2000, 1'b1, 1'b1, 1'b1, C_BR);
        access("R3 branch into NS window", 32'h4000_0100, 1'b1, 1'b1, 1'b0, C_NONE);
        access("R2 data into callable", 32'h4000_1004, 1'b1, 1'b0, 1'b0, C_DATA);
        access("R1 secure branch to S", 32'h4000_2000, 1'b0, 1'b1, 1'b0, C_NONE);
    endtask

    task automatic t_back_to_back;
        // two violating accesses in consecutive cycles give two pulses
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h0000_0000; acc_ns = 1'b1;
        acc_branch = 1'b0; acc_gateway = 1'b0;
        @(negedge clk);
        check("R9 first pulse", {30'd0, f_cause}, {30'd0, C_DATA});
        acc_branch = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R9 second pulse", {30'd0, f_cause}, {30'd0, C_BR});
        @(negedge clk);
        check("R9 idle after pair", {30'd0, f_sec, f_cause != 2'd0}, 32'd0);
    endtask

    task automatic t_reconfig;
        cfg_write(2'd1, 0, 32'h4000_0FE0);   // disable window 0
        query("R10 window disabled", 32'h4000_0100, 1'b0, A_S, 1'b0, 0, 1'b0);
        cfg_write(2'd2, 0, 32'h0);           // table off
        query("R4 table off again", 32'h4000_2000, 1'b0, A_NS, 1'b0, 0, 1'b0);
        check("R8 lite query same", {30'd0, lq_attr}, {30'd0, A_NS});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R9 actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed_map();
        t_faults_table_off();
        t_program();
        t_table_on();
        t_back_to_back();
        t_reconfig();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule